// File: doc/BRIEF.md
# On-Screen-Display Pixel Unpacker and Alpha Blender

This block overlays graphics on a live video pixel stream. It takes the graphics as packed 32-bit words through a valid/ready handshake. Each word holds pixel indices of 1, 2, 4 or 8 bits. The block maps every index through a 256-entry palette to a colour and a 4-bit transparency level, and mixes that colour into the video pixel under it. Outside a programmable rectangle, the video passes through untouched.

The video input carries one pixel per clock when valid. A frame marker flags the first pixel of a frame, and a line marker flags the first pixel of every line. The block counts columns and rows from these markers. Several overlays can share one frame if software reprograms the rectangle bounds between lines, because the bounds are read live. In the one-bit-per-pixel mode, an optional effect paints a fixed shadow colour on background pixels next to foreground pixels, which produces an outline around text. The output stream has the same markers as the input and arrives a fixed two clocks later.

Top module: `osd_blend`

## Requirements
- R1: `cfg_depth` selects the pixel size: 0 gives 1 bit, 1 gives 2 bits, 2 gives 4 bits and 3 gives 8 bits. Indices are taken from each word starting at the most significant bit, one index per overlay pixel.
- R2: `osd_ready` is high in exactly two cases: when no word is held, or when the last index of the held word is consumed in that cycle. A word is accepted when `osd_valid` and `osd_ready` are both high.
- R3: A write with `pal_we` high stores `pal_color` and `pal_alpha` into entry `pal_addr`. Overlay pixels with that index use the stored values from then on.
- R4: Each 8-bit colour component of an overlay pixel equals (video*(15-a) + palette*a + 7)/15, where a is the entry's alpha. So a=0 returns the video unchanged and a=15 returns the palette colour unchanged.
- R5: A pixel is an overlay pixel only when its column lies between `cfg_col_first` and `cfg_col_last` and its row between `cfg_row_first` and `cfg_row_last`, bounds included. Any other pixel leaves the video unchanged and consumes no index.
- R6: `vout_valid`, `vout_sof`, `vout_sol` and `vout_pix` follow the matching input pixel by exactly two clock cycles.
- R7: The shadow effect applies when `cfg_shadow_en` is 1 and `cfg_depth` is 0. It covers a background overlay pixel (index 0) in two cases: the overlay pixel to its left in the same row is foreground, and the pixel is not in the first region column; or the overlay pixel above it in the previous row is foreground, and the pixel is not in the first region row. Such a pixel outputs `cfg_shadow_color` exactly.
- R8: With `cfg_shadow_en` at 0, or with any `cfg_depth` other than 0, no pixel takes the shadow colour. Every overlay pixel is blended as in R4.
- R9: Right after reset, `vout_valid` is low and `osd_ready` is high.
- R10: An in-region pixel that arrives while no data word is held passes the video through unchanged.
- R11: The pixel that carries `vin_sof` is column 0 of row 0. A pixel that carries `vin_sol` (and not `vin_sof`) is column 0 of the next row. Every other valid pixel is one column to the right of the previous valid pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 2 | Bits-per-pixel select (R1 encoding) |
| cfg_shadow_en | input | 1 | Enable the shadow/outline effect |
| cfg_shadow_color | input | 24 | Colour painted on shadow pixels |
| cfg_col_first | input | 12 | First overlay column, inclusive |
| cfg_col_last | input | 12 | Last overlay column, inclusive |
| cfg_row_first | input | 12 | First overlay row, inclusive |
| cfg_row_last | input | 12 | Last overlay row, inclusive |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 8 | Palette entry to write |
| pal_color | input | 24 | Colour to store, three 8-bit components |
| pal_alpha | input | 4 | Transparency to store, 0 clear to 15 opaque |
| osd_data | input | 32 | Packed index word |
| osd_valid | input | 1 | `osd_data` holds a word |
| osd_ready | output | 1 | Block takes the offered word this cycle |
| vin_valid | input | 1 | Input video pixel present |
| vin_sof | input | 1 | First pixel of a frame |
| vin_sol | input | 1 | First pixel of a line |
| vin_pix | input | 24 | Input video pixel |
| vout_valid | output | 1 | Output pixel present |
| vout_sof | output | 1 | Delayed frame marker |
| vout_sol | output | 1 | Delayed line marker |
| vout_pix | output | 24 | Blended pixel |

## Verification
The bound checker watches several rules on every cycle. It checks the two-cycle delay of the valid and frame markers, and that the word fetch happens only when the held word runs out. It checks the two alpha extremes, where the output must equal one input exactly. It also checks that out-of-region pixels pass through, that shadow pixels take exactly the shadow colour, and that the shadow stays off whenever its mode conditions are not met. Other behaviours need the bench's scenarios to show them, because only an end-to-end model of the index stream can judge them. These are the intermediate alpha values with rounding, the most-significant-first order of indices in every depth, the neighbour rules of the shadow across rows, palette rewrites, and the pass-through of starved in-region pixels.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
package osd_pkg;
   localparam int IDX_W     = 8;
   localparam int ALPHA_W   = 4;
   localparam int ALPHA_MAX = 15;
   localparam int PAL_N     = 1 << IDX_W;

   typedef enum logic [1:0] {
      BPP1 = 2'd0,
      BPP2 = 2'd1,
      BPP4 = 2'd2,
      BPP8 = 2'd3
   } bpp_e;
endpackage

// File: rtl/osd_unpack.sv
`timescale 1ns/1ps
module osd_unpack
   import osd_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        depth,
   input  logic [WORD_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              take,
   output logic              have,
   output logic [IDX_W-1:0]  idx
);
   localparam int POS_W = $clog2(WORD_W) + 1;

   logic [WORD_W-1:0] word_q;
   logic [POS_W-1:0]  pos_q;
   logic              have_q;
   logic [POS_W-1:0]  bits;
   logic [WORD_W-1:0] shifted;
   logic              last;

   // word sits MSB-aligned after shifting out the bits already consumed
   assign bits    = POS_W'(1) << depth;
   assign shifted = word_q << pos_q;
   assign last    = have_q && ((pos_q + bits) == POS_W'(WORD_W));
   assign in_ready = !have_q || (take && last);
   assign have    = have_q;

   always_comb begin
      case (bpp_e'(depth))
         BPP1:    idx = {7'd0, shifted[WORD_W-1]};
         BPP2:    idx = {6'd0, shifted[WORD_W-1 -: 2]};
         BPP4:    idx = {4'd0, shifted[WORD_W-1 -: 4]};
         default: idx = shifted[WORD_W-1 -: 8];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         pos_q  <= '0;
         have_q <= 1'b0;
      end else if (in_valid && in_ready) begin
         word_q <= in_data;
         pos_q  <= '0;
         have_q <= 1'b1;
      end else if (take && have_q) begin
         pos_q <= pos_q + bits;
         if (last) have_q <= 1'b0;
      end
   end
endmodule

// File: rtl/osd_palette.sv
`timescale 1ns/1ps
module osd_palette
   import osd_pkg::*;
#(
   parameter int COLOR_W = 24
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_addr,
   input  logic [COLOR_W-1:0] wr_color,
   input  logic [ALPHA_W-1:0] wr_alpha,
   input  logic [IDX_W-1:0]   rd_addr,
   output logic [COLOR_W-1:0] rd_color,
   output logic [ALPHA_W-1:0] rd_alpha
);
   logic [COLOR_W-1:0] color_mem [PAL_N];
   logic [ALPHA_W-1:0] alpha_mem [PAL_N];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         color_mem[wr_addr] <= wr_color;
         alpha_mem[wr_addr] <= wr_alpha;
      end
      rd_color <= color_mem[rd_addr];
      rd_alpha <= alpha_mem[rd_addr];
   end
endmodule

// File: rtl/osd_shadow.sv
`timescale 1ns/1ps
module osd_shadow #(
   parameter int GEN_EN   = 1,
   parameter int MAX_COLS = 64,
   parameter int COORD_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               step,
   input  logic               fg,
   input  logic               first_col,
   input  logic               first_row,
   input  logic [COORD_W-1:0] col,
   output logic               shadow
);
   localparam int CI_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;

   if (GEN_EN != 0) begin : g_buf
      logic [MAX_COLS-1:0] above_q;
      logic                left_q;
      logic [CI_W-1:0]     ci;
      logic                above;

      assign ci     = col[CI_W-1:0];
      assign above  = above_q[ci];
      assign shadow = enable && step && !fg &&
                      ((!first_col && left_q) || (!first_row && above));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            above_q <= '0;
            left_q  <= 1'b0;
         end else if (step) begin
            above_q[ci] <= fg;
            left_q      <= fg;
         end
      end
   end else begin : g_none
      assign shadow = 1'b0;
   end
endmodule

// File: rtl/osd_mix.sv
`timescale 1ns/1ps
module osd_mix
   import osd_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int NCOMP  = 3
) (
   input  logic [COMP_W*NCOMP-1:0] video,
   input  logic [COMP_W*NCOMP-1:0] color,
   input  logic [ALPHA_W-1:0]      alpha,
   input  logic                    overlay,
   input  logic                    shade,
   input  logic [COMP_W*NCOMP-1:0] shade_color,
   output logic [COMP_W*NCOMP-1:0] pix
);
   localparam int ACC_W = COMP_W + ALPHA_W + 1;

   logic [COMP_W*NCOMP-1:0] blended;
   logic [ALPHA_W-1:0]      inv;

   assign inv = ALPHA_W'(ALPHA_MAX) - alpha;

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      logic [ACC_W-1:0] acc;
      assign acc = ACC_W'(video[k*COMP_W +: COMP_W]) * ACC_W'(inv)
                 + ACC_W'(color[k*COMP_W +: COMP_W]) * ACC_W'(alpha)
                 + ACC_W'(ALPHA_MAX / 2);
      assign blended[k*COMP_W +: COMP_W] = COMP_W'(acc / ACC_W'(ALPHA_MAX));
   end

   always_comb begin
      if (shade)        pix = shade_color;
      else if (overlay) pix = blended;
      else              pix = video;
   end
endmodule

// File: rtl/osd_blend.sv
`timescale 1ns/1ps
module osd_blend
   import osd_pkg::*;
#(
   parameter int COMP_W     = 8,
   parameter int NCOMP      = 3,
   parameter int WORD_W     = 32,
   parameter int COORD_W    = 12,
   parameter int MAX_COLS   = 64,
   parameter int SHADOW_GEN = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               cfg_depth,
   input  logic                     cfg_shadow_en,
   input  logic [COMP_W*NCOMP-1:0]  cfg_shadow_color,
   input  logic [COORD_W-1:0]       cfg_col_first,
   input  logic [COORD_W-1:0]       cfg_col_last,
   input  logic [COORD_W-1:0]       cfg_row_first,
   input  logic [COORD_W-1:0]       cfg_row_last,
   input  logic                     pal_we,
   input  logic [7:0]               pal_addr,
   input  logic [COMP_W*NCOMP-1:0]  pal_color,
   input  logic [3:0]               pal_alpha,
   input  logic [WORD_W-1:0]        osd_data,
   input  logic                     osd_valid,
   output logic                     osd_ready,
   input  logic                     vin_valid,
   input  logic                     vin_sof,
   input  logic                     vin_sol,
   input  logic [COMP_W*NCOMP-1:0]  vin_pix,
   output logic                     vout_valid,
   output logic                     vout_sof,
   output logic                     vout_sol,
   output logic [COMP_W*NCOMP-1:0]  vout_pix
);
   localparam int PIX_W = COMP_W * NCOMP;

   if (WORD_W < IDX_W || (WORD_W % IDX_W) != 0) begin : g_bad_word
      $error("osd_blend: WORD_W must be a multiple of %0d", IDX_W);
   end
   if (MAX_COLS < 2) begin : g_bad_cols
      $error("osd_blend: MAX_COLS must be at least 2");
   end
   if (COMP_W < 1 || NCOMP < 1) begin : g_bad_pix
      $error("osd_blend: pixel shape must be non-empty");
   end

   // ---- stage A: position tracking and region test ----
   logic [COORD_W-1:0] col_q, row_q, col_c, row_c;
   logic               in_rgn, have_w, ovl_c, shd_c;
   logic [IDX_W-1:0]   idx_w;

   assign col_c = (vin_sof || vin_sol) ? '0 : col_q + 1'b1;
   assign row_c = vin_sof ? '0 : (vin_sol ? row_q + 1'b1 : row_q);
   assign in_rgn = vin_valid &&
                   (col_c >= cfg_col_first) && (col_c <= cfg_col_last) &&
                   (row_c >= cfg_row_first) && (row_c <= cfg_row_last);
   assign ovl_c = in_rgn && have_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (vin_valid) begin
         col_q <= col_c;
         row_q <= row_c;
      end
   end

   osd_unpack #(.WORD_W(WORD_W)) u_unp (
      .clk      (clk),
      .rst_n    (rst_n),
      .depth    (cfg_depth),
      .in_data  (osd_data),
      .in_valid (osd_valid),
      .in_ready (osd_ready),
      .take     (in_rgn),
      .have     (have_w),
      .idx      (idx_w)
   );

   osd_shadow #(.GEN_EN(SHADOW_GEN), .MAX_COLS(MAX_COLS), .COORD_W(COORD_W)) u_shd (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (cfg_shadow_en && (cfg_depth == 2'd0)),
      .step      (ovl_c),
      .fg        (idx_w != '0),
      .first_col (col_c == cfg_col_first),
      .first_row (row_c == cfg_row_first),
      .col       (col_c),
      .shadow    (shd_c)
   );

   // ---- stage 1: registered pixel plus palette read ----
   logic             s1_valid, s1_sof, s1_sol, s1_ovl, s1_shd;
   logic [PIX_W-1:0] s1_pix, pal_q_color, mix_pix;
   logic [3:0]       pal_q_alpha;

   osd_palette #(.COLOR_W(PIX_W)) u_pal (
      .clk      (clk),
      .wr_en    (pal_we),
      .wr_addr  (pal_addr),
      .wr_color (pal_color),
      .wr_alpha (pal_alpha),
      .rd_addr  (idx_w),
      .rd_color (pal_q_color),
      .rd_alpha (pal_q_alpha)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sof   <= 1'b0;
         s1_sol   <= 1'b0;
         s1_ovl   <= 1'b0;
         s1_shd   <= 1'b0;
         s1_pix   <= '0;
      end else begin
         s1_valid <= vin_valid;
         s1_sof   <= vin_sof && vin_valid;
         s1_sol   <= vin_sol && vin_valid;
         s1_ovl   <= ovl_c;
         s1_shd   <= shd_c;
         s1_pix   <= vin_pix;
      end
   end

   // ---- stage 2: blend and output register ----
   osd_mix #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_mix (
      .video       (s1_pix),
      .color       (pal_q_color),
      .alpha       (pal_q_alpha),
      .overlay     (s1_ovl),
      .shade       (s1_shd),
      .shade_color (cfg_shadow_color),
      .pix         (mix_pix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vout_valid <= 1'b0;
         vout_sof   <= 1'b0;
         vout_sol   <= 1'b0;
         vout_pix   <= '0;
      end else begin
         vout_valid <= s1_valid;
         vout_sof   <= s1_sof;
         vout_sol   <= s1_sol;
         vout_pix   <= mix_pix;
      end
   end
endmodule

// File: rtl/osd_blend_chk.sv
`timescale 1ns/1ps
module osd_blend_chk #(
   parameter int PIX_W  = 24,
   parameter int WORD_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_depth,
   input logic             cfg_shadow_en,
   input logic [PIX_W-1:0] cfg_shadow_color,
   input logic             osd_valid,
   input logic             osd_ready,
   input logic             in_rgn,
   input logic             have_w,
   input logic             vin_valid,
   input logic             vin_sof,
   input logic             vout_valid,
   input logic             vout_sof,
   input logic [PIX_W-1:0] vout_pix,
   input logic             s1_valid,
   input logic             s1_ovl,
   input logic             s1_shd,
   input logic [PIX_W-1:0] s1_pix,
   input logic [PIX_W-1:0] pal_q_color,
   input logic [3:0]       pal_q_alpha
);
   localparam int U_W = $clog2(WORD_W) + 2;

   logic [1:0]     cyc_q;
   logic [U_W-1:0] used_q, bits_c;

   assign bits_c = U_W'(1) << cfg_depth;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         used_q <= '0;
      end else begin
         if (cyc_q != 2'd2) cyc_q <= cyc_q + 1'b1;
         if (osd_valid && osd_ready) used_q <= '0;
         else if (in_rgn && have_w) used_q <= used_q + bits_c;
      end
   end

   assert_fetch_on_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (have_w && osd_ready) |-> (in_rgn && (used_q + bits_c == U_W'(WORD_W))));

   assert_clear_alpha_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_ovl && !s1_shd && pal_q_alpha == 4'd0) |=> (vout_pix == $past(s1_pix)));

   assert_opaque_alpha_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_ovl && !s1_shd && pal_q_alpha == 4'd15) |=> (vout_pix == $past(pal_q_color)));

   assert_outside_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_ovl && !s1_shd) |=> (vout_pix == $past(s1_pix)));

   assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd2) |-> (vout_valid == $past(vin_valid, 2)));

   assert_frame_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd2) |-> (vout_sof == $past(vin_sof && vin_valid, 2)));

   assert_shadow_color_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s1_shd |=> (vout_pix == $past(cfg_shadow_color)));

   assert_shadow_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_shadow_en || cfg_depth != 2'd0) |=> !s1_shd);
endmodule

bind osd_blend osd_blend_chk #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_depth        (cfg_depth),
   .cfg_shadow_en    (cfg_shadow_en),
   .cfg_shadow_color (cfg_shadow_color),
   .osd_valid        (osd_valid),
   .osd_ready        (osd_ready),
   .in_rgn           (in_rgn),
   .have_w           (have_w),
   .vin_valid        (vin_valid),
   .vin_sof          (vin_sof),
   .vout_valid       (vout_valid),
   .vout_sof         (vout_sof),
   .vout_pix         (vout_pix),
   .s1_valid         (s1_valid),
   .s1_ovl           (s1_ovl),
   .s1_shd           (s1_shd),
   .s1_pix           (s1_pix),
   .pal_q_color      (pal_q_color),
   .pal_q_alpha      (pal_q_alpha)
);

// File: tb/osd_blend_bench.sv
`timescale 1ns/1ps
module osd_blend_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_depth = 2'd0;
   logic        cfg_shadow_en = 1'b0;
   logic [23:0] cfg_shadow_color = 24'h102030;
   logic [11:0] cfg_col_first = '0, cfg_col_last = '0, cfg_row_first = '0, cfg_row_last = '0;
   logic        pal_we = 1'b0;
   logic [7:0]  pal_addr = '0;
   logic [23:0] pal_color = '0;
   logic [3:0]  pal_alpha = '0;
   logic [31:0] osd_data = '0;
   logic        osd_valid = 1'b0;
   logic        osd_ready;
   logic        vin_valid = 1'b0, vin_sof = 1'b0, vin_sol = 1'b0;
   logic [23:0] vin_pix = '0;
   logic        vout_valid, vout_sof, vout_sol;
   logic [23:0] vout_pix;

   osd_blend u_osd_blend (.*);

   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int bad = 0;
   int cyc = 0;
   int seed_dummy;
   bit feed_en = 1'b1;
   logic [31:0] cur_word;

   logic [23:0] pc [256];
   logic [3:0]  pa [256];
   int          idxq [$];
   logic [23:0] e_pix [$];
   int          e_cyc [$];
   bit          e_sof [$];
   bit          e_sol [$];
   string       e_tag [$];
   int          mcol, mrow;
   bit          lbuf [64];
   bit          prevfg;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [23:0] blend(input logic [23:0] v, input logic [23:0] o, input logic [3:0] a);
      logic [23:0] r;
      for (int k = 0; k < 3; k++) begin
         int vv = int'(v[k*8 +: 8]);
         int oo = int'(o[k*8 +: 8]);
         r[k*8 +: 8] = 8'((vv * (15 - int'(a)) + oo * int'(a) + 7) / 15);
      end
      return r;
   endfunction

   task automatic push_word(input logic [31:0] w);
      int bits = 1 << cfg_depth;
      for (int p = 0; p < 32; p += bits)
         idxq.push_back(int'((w >> (32 - bits - p)) & ((32'd1 << bits) - 1)));
   endtask

   // one pixel clock: drive, then sample and model away from the edge
   task automatic cycle(input bit v, input bit sof, input bit sol, input logic [23:0] pix);
      bit inr, take, exp_ready, fg, shd;
      int idx;
      logic [23:0] ex;
      string tag;
      @(negedge clk);
      vin_valid = v; vin_sof = sof; vin_sol = sol; vin_pix = pix;
      osd_valid = feed_en; osd_data = cur_word;
      #5;
      if (vout_valid) begin
         if (e_pix.size() == 0) check(1'b0, "R6 unexpected output", 1, 0);
         else begin
            check(e_cyc[0] == cyc, "R6 latency", cyc, e_cyc[0]);
            check({vout_sof, vout_sol} == {e_sof[0], e_sol[0]}, "R6 R11 markers",
                  {vout_sof, vout_sol}, {e_sof[0], e_sol[0]});
            check(vout_pix == e_pix[0], e_tag[0], vout_pix, e_pix[0]);
            void'(e_pix.pop_front()); void'(e_cyc.pop_front());
            void'(e_sof.pop_front()); void'(e_sol.pop_front()); void'(e_tag.pop_front());
         end
      end
      inr = 1'b0;
      if (v) begin
         if (sof) begin mcol = 0; mrow = 0; end
         else if (sol) begin mcol = 0; mrow++; end
         else mcol++;
         inr = mcol >= cfg_col_first && mcol <= cfg_col_last &&
               mrow >= cfg_row_first && mrow <= cfg_row_last;
      end
      take = inr && idxq.size() > 0;
      exp_ready = (idxq.size() == 0) || (take && idxq.size() == 1);
      check(osd_ready == exp_ready, "R2 ready", osd_ready, exp_ready);
      if (v) begin
         if (take) begin
            idx = idxq.pop_front();
            fg = idx != 0;
            shd = cfg_shadow_en && cfg_depth == 0 && !fg &&
                  ((mcol > cfg_col_first && prevfg) || (mrow > cfg_row_first && lbuf[mcol]));
            lbuf[mcol] = fg; prevfg = fg;
            if (shd) begin ex = cfg_shadow_color; tag = "R7 shadow"; end
            else begin
               ex = blend(pix, pc[idx], pa[idx]);
               tag = cfg_shadow_en ? "R8 R4 no-shadow blend" : "R1 R3 R4 blend";
            end
         end else if (inr) begin ex = pix; tag = "R10 starved pass"; end
         else begin ex = pix; tag = "R5 outside pass"; end
         e_pix.push_back(ex); e_cyc.push_back(cyc + 2);
         e_sof.push_back(sof); e_sol.push_back(sol); e_tag.push_back(tag);
      end
      if (osd_valid && osd_ready) begin
         push_word(cur_word);
         cur_word = $urandom;
      end
      cyc++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; vin_valid = 1'b0; osd_valid = 1'b0; pal_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idxq.delete(); e_pix.delete(); e_cyc.delete(); e_sof.delete(); e_sol.delete(); e_tag.delete();
      foreach (lbuf[i]) lbuf[i] = 1'b0;
      prevfg = 1'b0; mcol = 0; mrow = 0;
      cur_word = $urandom;
      #5;
      check(vout_valid == 1'b0, "R9 vout_valid after reset", vout_valid, 0);
      check(osd_ready == 1'b1, "R9 osd_ready after reset", osd_ready, 1);
   endtask

   task automatic write_pal(input int i, input logic [23:0] c, input logic [3:0] a);
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'(i); pal_color = c; pal_alpha = a;
      pc[i] = c; pa[i] = a;
      @(negedge clk);
      pal_we = 1'b0;
   endtask

   task automatic run_frame(input int w, input int h, input int gap_pct);
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w; c++) begin
            while (($urandom % 100) < gap_pct) cycle(1'b0, 1'b0, 1'b0, 24'h0);
            cycle(1'b1, r == 0 && c == 0, c == 0, 24'($urandom));
         end
      repeat (4) cycle(1'b0, 1'b0, 1'b0, 24'h0);
      check(e_pix.size() == 0, "R6 drain", e_pix.size(), 0);
   endtask

   task automatic set_region(input int cf, input int cl, input int rf, input int rl);
      cfg_col_first = 12'(cf); cfg_col_last = 12'(cl);
      cfg_row_first = 12'(rf); cfg_row_last = 12'(rl);
   endtask

   initial begin
      #3_000_000;
      bad++; checks++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'h5eed_0c1d);
      do_reset();
      // palette: force alpha extremes on some entries, random elsewhere
      for (int i = 0; i < 256; i++)
         write_pal(i, 24'($urandom), (i % 5 == 0) ? 4'd0 : (i % 5 == 1) ? 4'd15 : 4'($urandom));
      // R1: every depth with a random partial region
      for (int d = 0; d < 4; d++) begin
         do_reset();
         cfg_depth = 2'(d); cfg_shadow_en = 1'b0;
         set_region($urandom % 10, 20 + $urandom % 20, 1 + $urandom % 3, 5 + $urandom % 4);
         run_frame(40, 10, 20);
         run_frame(40, 10, 20);
      end
      // R3: rewrite entries then reuse them at 1 bit per pixel
      write_pal(0, 24'h00ff00, 4'd7);
      write_pal(1, 24'hff0000, 4'd9);
      do_reset();
      cfg_depth = 2'd0;
      set_region(2, 30, 0, 7);
      run_frame(36, 8, 10);
      // R5: full-screen region at 8 bits per pixel
      do_reset();
      cfg_depth = 2'd3;
      set_region(0, 4095, 0, 4095);
      run_frame(24, 6, 10);
      // R7: shadow around foreground in 1-bit mode
      do_reset();
      cfg_depth = 2'd0; cfg_shadow_en = 1'b1; cfg_shadow_color = 24'h203040;
      set_region(3, 33, 2, 9);
      run_frame(40, 11, 15);
      run_frame(40, 11, 15);
      // R8: shadow enabled but depth is 4 bits
      do_reset();
      cfg_depth = 2'd2;
      set_region(0, 30, 0, 8);
      run_frame(36, 9, 10);
      cfg_shadow_en = 1'b0;
      // R10: starved stream passes video, then the stream resumes
      do_reset();
      cfg_depth = 2'd1; feed_en = 1'b0;
      set_region(5, 25, 1, 6);
      run_frame(32, 8, 10);
      feed_en = 1'b1;
      run_frame(32, 8, 10);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule